// File: doc/BRIEF.md
# Serial Command Programming Engine

This block sits between a host register port and a remote sensor macro that can only be reached over a narrow serial link. The host writes one packed 32-bit command word. The word holds a start flag, a direction flag, a small remote register address and a data payload. The engine turns that word into a serial frame: a divided serial clock, one data-out line, one data-in line, and a single-cycle strobe that ends the frame.

The host sees a two-bit status value. Bit 0 is busy and bit 1 is lock. The host waits for busy to clear before it writes the next command. On the remote side, register 0 is control, 1 is configuration, 3 is data, 4 is polling and 5 is timer. In the remote control word, bit 1 releases reset, bit 3 selects continuous running, bit 8 selects automatic mode and bit 10 selects voltage-monitor mode.

A separate one-bit disable register gates the link. It comes out of reset set, so the host must clear it before any command is accepted. A remote read returns 24 bits on the data-in line. Those bits land in a read-back register, which is flagged valid at the moment busy falls.

Top module: `ser_cmd_engine`

## Requirements
- R1: While reset is low and just after it is released, status is 0, the serial clock, data-out and strobe are low, and read-back valid is low.
- R2: Status bit 1 (lock) is high exactly when the disable register is 0. The disable register resets to 1 and takes the value of `dis_wdata` one cycle after a `dis_wr` pulse.
- R3: A command write with bit 31 set, accepted while idle and unlocked, raises status bit 0 (busy) on the next cycle.
- R4: A command write with bit 31 clear starts nothing and leaves every output unchanged.
- R5: A command written while busy is ignored. The frame in flight continues unaltered, and busy stays high.
- R6: A command written while the disable register is 1 is ignored. Setting disable during a frame does not cut that frame short.
- R7: The frame is 28 bits, most significant first. It carries command bit 27 (1 = write, 0 = read), then bits 26:24 (address), then bits 23:0 (payload). Bits 30:28 have no effect.
- R8: Each frame bit lasts 2*HALF clock cycles. The serial clock is low for the first HALF cycles and high for the last HALF, and data-out changes only at a bit boundary.
- R9: On a read, the 24 payload bit slots carry zeros on data-out. Data-in is sampled on each rising serial clock during those slots, most significant bit first.
- R10: The strobe is high for exactly one cycle, on the cycle after the last bit. Busy falls on the following cycle.
- R11: After a read, the read-back register holds the 24 sampled bits and valid rises as busy falls. Valid drops when the next command is accepted, and a write never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write pulse |
| cmd_wdata | input | 32 | Command word |
| dis_wr | input | 1 | Disable register write pulse |
| dis_wdata | input | 1 | Disable value (1 = link gated) |
| stat | output | 2 | Status: bit 0 busy, bit 1 lock |
| rd_data | output | 24 | Read-back data from the last read |
| rd_valid | output | 1 | Read-back data valid |
| link_sclk | output | 1 | Serial clock toward the macro |
| link_sdo | output | 1 | Serial data toward the macro |
| link_sdi | input | 1 | Serial data from the macro |
| link_stb | output | 1 | End-of-frame strobe |

## Verification
The bench fires a second command halfway through a frame. A design that let that write through would reload the shift register and put the wrong bits on data-out, and the per-cycle comparison would show it. The bench also writes commands with the start bit clear, with the link disabled, and with bits 30:28 set. A design that decoded any of those would raise busy or emit frame bits that the model does not expect. Reads use an asymmetric reply pattern, so a design that sampled on the wrong serial edge, shifted in the wrong order, or kept valid high across the next command would show up in the read-back value or in the valid flag.

// File: rtl/sce_pkg.sv
package sce_pkg;
    localparam int START_BIT = 31;
    localparam int WNR_BIT   = 27;
    localparam int ADDR_LSB  = 24;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_STROBE = 2'd2
    } sce_state_e;
endpackage

// File: rtl/sce_bitclk.sv
module sce_bitclk #(
    parameter int HALF  = 2,
    parameter int NBITS = 28,
    localparam int PH_W  = (2 * HALF > 1) ? $clog2(2 * HALF) : 1,
    localparam int BIT_W = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic             sclk,
    output logic             bit_end,
    output logic             rise,
    output logic             last,
    output logic [BIT_W-1:0] bit_idx
);
    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitn;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.ph   = '0;
            d.bitn = '0;
        end else if (run) begin
            if (q.ph == PH_W'(2 * HALF - 1)) begin
                d.ph   = '0;
                d.bitn = q.bitn + 1'b1;
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = run && (q.ph >= PH_W'(HALF));
    assign bit_end = run && (q.ph == PH_W'(2 * HALF - 1));
    assign rise    = run && (q.ph == PH_W'(HALF - 1));
    assign last    = bit_end && (q.bitn == BIT_W'(NBITS - 1));
    assign bit_idx = q.bitn;
endmodule

// File: rtl/sce_shifter.sv
module sce_shifter #(
    parameter int NBITS  = 28,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NBITS-1:0]  load_word,
    input  logic              shift_tx,
    input  logic              shift_rx,
    input  logic              sdi,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_word
);
    typedef struct packed {
        logic [NBITS-1:0]  tx;
        logic [DATA_W-1:0] rx;
    } shf_t;

    shf_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.tx = load_word;
            d.rx = '0;
        end else begin
            if (shift_tx) d.tx = {q.tx[NBITS-2:0], 1'b0};
            if (shift_rx) d.rx = {q.rx[DATA_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_msb  = q.tx[NBITS-1];
    assign rx_word = q.rx;
endmodule

// File: rtl/ser_cmd_engine.sv
module ser_cmd_engine
    import sce_pkg::*;
#(
    parameter int HALF   = 2,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 24,
    localparam int NBITS = 1 + ADDR_W + DATA_W,
    localparam int BIT_W = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [31:0]       cmd_wdata,
    input  logic              dis_wr,
    input  logic              dis_wdata,
    output logic [1:0]        stat,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              link_sclk,
    output logic              link_sdo,
    input  logic              link_sdi,
    output logic              link_stb
);
    typedef struct packed {
        sce_state_e        st;
        logic              wnr;
        logic              dis;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } ctl_t;

    ctl_t d, q;

    logic             accept;
    logic             wnr_in;
    logic [NBITS-1:0] frame;
    logic             run;
    logic             sclk_raw, bit_end, rise, last;
    logic [BIT_W-1:0] bit_idx;
    logic             tx_msb;
    logic [DATA_W-1:0] rx_word;
    logic             cmd_unused;

    assign cmd_unused = &{1'b0, cmd_wdata[30:28]};

    assign wnr_in = cmd_wdata[WNR_BIT];
    assign accept = cmd_wr && cmd_wdata[START_BIT] && (q.st == ST_IDLE) && !q.dis;
    assign frame  = {wnr_in, cmd_wdata[ADDR_LSB +: ADDR_W],
                     wnr_in ? cmd_wdata[DATA_W-1:0] : {DATA_W{1'b0}}};
    assign run    = (q.st == ST_SHIFT);

    always_comb begin
        d = q;
        if (dis_wr) d.dis = dis_wdata;
        case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st     = ST_SHIFT;
                    d.wnr    = wnr_in;
                    d.rvalid = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (last) d.st = ST_STROBE;
            end
            ST_STROBE: begin
                d.st = ST_IDLE;
                if (!q.wnr) begin
                    d.rdata  = rx_word;
                    d.rvalid = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.dis    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    sce_bitclk #(.HALF(HALF), .NBITS(NBITS)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .run     (run),
        .sclk    (sclk_raw),
        .bit_end (bit_end),
        .rise    (rise),
        .last    (last),
        .bit_idx (bit_idx)
    );

    sce_shifter #(.NBITS(NBITS), .DATA_W(DATA_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (frame),
        .shift_tx  (bit_end),
        .shift_rx  (rise && !q.wnr && (bit_idx >= BIT_W'(1 + ADDR_W))),
        .sdi       (link_sdi),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    assign stat      = {!q.dis, q.st != ST_IDLE};
    assign rd_data   = q.rdata;
    assign rd_valid  = q.rvalid;
    assign link_sclk = sclk_raw;
    assign link_sdo  = run && tx_msb;
    assign link_stb  = (q.st == ST_STROBE);
endmodule

// File: rtl/ser_cmd_engine_chk.sv
module ser_cmd_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic        dis_wr,
    input logic        dis_wdata,
    input logic [1:0]  stat,
    input logic        rd_valid,
    input logic        link_sclk,
    input logic        link_stb
);
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(cmd_wr && cmd_wdata[31] && stat[1]));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && cmd_wr && !link_stb) |=> stat[0]);

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_stb |=> (!link_stb && !stat[0]));

    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[0] |-> !link_sclk);

    // R2
    lock_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> (stat[1] == !$past(dis_wdata)));

    // R11
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $fell(stat[0]));
endmodule

bind ser_cmd_engine ser_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .dis_wr    (dis_wr),
    .dis_wdata (dis_wdata),
    .stat      (stat),
    .rd_valid  (rd_valid),
    .link_sclk (link_sclk),
    .link_stb  (link_stb)
);

// File: tb/ser_cmd_engine_bench.sv
module ser_cmd_engine_bench;
    localparam int H  = 2;
    localparam int NB = 28;
    localparam int FRAME_CYC = NB * 2 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        dis_wr = 1'b0;
    logic        dis_wdata = 1'b0;
    logic [1:0]  stat;
    logic [23:0] rd_data;
    logic        rd_valid;
    logic        link_sclk, link_sdo, link_sdi, link_stb;

    int vectors = 0;
    int misses  = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic        m_active = 1'b0;
    int          m_e = 0;
    logic [27:0] m_frame = '0;
    logic        m_wnr = 1'b0;
    logic        m_lock = 1'b0;
    logic [23:0] m_rdata = '0;
    logic        m_rvalid = 1'b0;
    logic [23:0] reply = '0;

    always #2 clk = ~clk;

    ser_cmd_engine #(.HALF(H)) u_ser_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .dis_wr(dis_wr), .dis_wdata(dis_wdata), .stat(stat),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_sclk(link_sclk),
        .link_sdo(link_sdo), .link_sdi(link_sdi), .link_stb(link_stb)
    );

    // macro reply: payload slot k (bit index 4..27) returns reply MSB first
    assign link_sdi = (m_active && m_e < FRAME_CYC && (m_e / (2 * H)) >= 4)
                      ? reply[23 - ((m_e / (2 * H)) - 4)] : 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_active <= 1'b0; m_e <= 0; m_lock <= 1'b0;
            m_rvalid <= 1'b0; m_rdata <= '0;
        end else begin
            if (m_active) begin
                if (m_e == FRAME_CYC) begin
                    m_active <= 1'b0;
                    if (!m_wnr) begin m_rdata <= reply; m_rvalid <= 1'b1; end
                end else begin
                    m_e <= m_e + 1;
                end
            end else if (cmd_wr && cmd_wdata[31] && m_lock) begin
                m_active <= 1'b1;
                m_e      <= 0;
                m_wnr    <= cmd_wdata[27];
                m_frame  <= {cmd_wdata[27], cmd_wdata[26:24],
                             cmd_wdata[27] ? cmd_wdata[23:0] : 24'h0};
                m_rvalid <= 1'b0;
            end
            if (dis_wr) m_lock <= !dis_wdata;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s (during %s): actual %0h expected %0h at %0t",
                     req, cur_req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic e_sclk, e_sdo, e_stb;
        e_stb  = m_active && (m_e == FRAME_CYC);
        e_sclk = m_active && (m_e < FRAME_CYC) && ((m_e % (2 * H)) >= H);
        e_sdo  = m_active && (m_e < FRAME_CYC) && m_frame[NB - 1 - m_e / (2 * H)];
        chk(stat[0] === m_active, "R3 busy", 32'(stat[0]), 32'(m_active));
        chk(stat[1] === m_lock, "R2 lock", 32'(stat[1]), 32'(m_lock));
        chk(link_sclk === e_sclk, "R8 sclk", 32'(link_sclk), 32'(e_sclk));
        chk(link_sdo === e_sdo, "R7 sdo", 32'(link_sdo), 32'(e_sdo));
        chk(link_stb === e_stb, "R10 strobe", 32'(link_stb), 32'(e_stb));
        chk(rd_valid === m_rvalid, "R11 valid", 32'(rd_valid), 32'(m_rvalid));
        if (m_rvalid)
            chk(rd_data === m_rdata, "R9 rdata", 32'(rd_data), 32'(m_rdata));
    end

    task automatic issue(input logic [31:0] w);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic set_dis(input logic v);
        @(negedge clk); dis_wr = 1'b1; dis_wdata = v;
        @(negedge clk); dis_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < FRAME_CYC + 10; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk(stat == 2'b00 && !link_sclk && !link_sdo && !link_stb && !rd_valid,
            "R1 reset", {27'b0, stat, link_sclk, link_sdo, link_stb}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat == 2'b00 && !rd_valid, "R1 after release", 32'(stat), 32'h0);

        cur_req = "R6";
        issue(32'h8800_0001);
        repeat (3) @(negedge clk);
        chk(stat[0] == 1'b0, "R6 disabled ignore", 32'(stat[0]), 32'h0);

        cur_req = "R2";
        set_dis(1'b0);
        chk(stat[1] == 1'b1, "R2 lock set", 32'(stat[1]), 32'h1);

        cur_req = "R4";
        issue(32'h0800_00FF);
        repeat (3) @(negedge clk);
        chk(stat[0] == 1'b0 && !link_sdo, "R4 no start", 32'(stat[0]), 32'h0);

        cur_req = "R7";
        issue(32'h8D00_0080);
        chk(stat[0] == 1'b1, "R3 busy next cycle", 32'(stat[0]), 32'h1);
        wait_idle();
        chk(!rd_valid, "R11 write no valid", 32'(rd_valid), 32'h0);

        issue(32'hF800_050A);
        wait_idle();

        cur_req = "R9";
        reply = 24'hA5C3E1;
        issue(32'h8300_FFFF);
        wait_idle();
        chk(rd_valid && rd_data == 24'hA5C3E1, "R11 readback",
            {7'b0, rd_valid, rd_data}, {8'h01, 24'hA5C3E1});

        cur_req = "R5";
        reply = 24'h13579B;
        issue(32'h8400_0000);
        chk(rd_valid == 1'b0, "R11 valid drop", 32'(rd_valid), 32'h0);
        repeat (40) @(negedge clk);
        issue(32'h8D12_3456);
        chk(stat[0] == 1'b1, "R5 busy kept", 32'(stat[0]), 32'h1);
        wait_idle();
        chk(rd_data == 24'h13579B, "R5 frame intact", 32'(rd_data), 32'h13579B);

        cur_req = "R6";
        issue(32'h8900_0F0F);
        repeat (20) @(negedge clk);
        set_dis(1'b1);
        chk(stat[0] == 1'b1, "R6 frame continues", 32'(stat[0]), 32'h1);
        wait_idle();
        issue(32'h8900_0001);
        repeat (3) @(negedge clk);
        chk(stat == 2'b00, "R6 disabled again", 32'(stat), 32'h0);

        cur_req = "R10";
        set_dis(1'b0);
        issue(32'h8C00_0001);
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule